// File: doc/BRIEF.md
# Two-Phase Toggle Word Link

This block carries one data word at a time between two clock domains that have no fixed phase or frequency relation. The sending side registers the word and then flips a single request line. The receiving side sees that flip after a synchronizer and captures the word. It then flips an acknowledge line back. Neither line returns to a rest level. An event is any change of level, so consecutive transfers use rising and falling edges in turn, and a full exchange takes two wire transitions.

Each side keeps a stored copy of the level it last saw, so it can detect the next change. The link is idle when the request and acknowledge levels agree. A transfer is in flight when they disagree. Both sides use valid/ready streams.

On the source side a word moves on a cycle where `s_valid` and `s_ready` are both high. `s_ready` is the inverse of a busy indication: it stays low from the cycle after a word is accepted until the matching acknowledge has crossed back. While `s_ready` is low, `s_valid` and `s_data` have no effect.

On the sink side `m_valid` stays high with `m_data` unchanged until `m_ready` is sampled high. While the output register is occupied and not draining, the receiver leaves a pending word uncaptured and does not flip the acknowledge. That back-pressure reaches the source as a longer busy period.

Top module: `nrz_word_link`

## Requirements
- R1: After reset, `link_req` and `link_ack` are 0, `s_ready` is 1 and `m_valid` is 0.
- R2: `s_ready` is high exactly when the request level equals the synchronized acknowledge level. On the source clock cycle after an accepted word, `s_ready` is low.
- R3: Each accepted word inverts `link_req` exactly once, on the source clock edge that accepts it. `link_req` does not change on any other edge, so successive transfers alternate rising and falling edges.
- R4: Every accepted word appears on `m_data` exactly once, unchanged and in acceptance order. The source side holds its word register stable while a transfer is in flight.
- R5: While `m_valid` is high and `m_ready` is low, `m_valid` stays high, `m_data` is stable and `link_ack` does not change.
- R6: A source-side `s_valid` presented while `s_ready` is low is ignored: no extra word is ever delivered for it.
- R7: Delivery is correct when the source clock is faster than, slower than, or equal to the sink clock, including under sink stalls.
- R8: `link_ack` changes only on a sink edge that loads a word into the output register. Once all words have drained, `link_req` equals `link_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| s_valid | input | 1 | Source word is offered |
| s_ready | output | 1 | Link can accept a word (low means busy) |
| s_data | input | W | Source word |
| dst_clk | input | 1 | Sink domain clock |
| dst_rst_n | input | 1 | Sink domain reset, active low |
| m_valid | output | 1 | Output register holds a word |
| m_ready | input | 1 | Sink takes the word this cycle |
| m_data | output | W | Delivered word |
| link_req | output | 1 | Request toggle line, driven by a flop |
| link_ack | output | 1 | Acknowledge toggle line, driven by a flop |

## Verification
The bench targets several failure modes:
- Back-to-back pushes across three clock-ratio classes. A design that detects levels instead of changes would deliver only every other word, or repeat one.
- Offers made during the busy window. A design that accepts them would clobber the in-flight word or add an extra delivery.
- A sink that stalls with a second word pending. A design that acknowledges before it has space would lose the first word.
- Counting request and acknowledge toggles against the number of words delivered. This exposes a side that fails to update its stored level and so re-fires or stalls.

// File: rtl/nrz_link_pkg.sv
package nrz_link_pkg;
  localparam int unsigned MIN_SYNC_STAGES = 2;

  // A pending event exists whenever the two levels disagree.
  function automatic logic levels_differ(input logic a, input logic b);
    return a ^ b;
  endfunction
endpackage

// File: rtl/nrz_level_sync.sv
module nrz_level_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  localparam int unsigned N = (STAGES < nrz_link_pkg::MIN_SYNC_STAGES) ?
                              nrz_link_pkg::MIN_SYNC_STAGES : STAGES;

  logic [N-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[N-2:0], d_async};
  end

  assign q_sync = chain_q[N-1];
endmodule

// File: rtl/nrz_tx_side.sv
module nrz_tx_side #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  input  logic         ack_async,
  output logic         req_out,
  output logic [W-1:0] word_out
);
  import nrz_link_pkg::*;

  logic         req_q;
  logic         ack_seen;
  logic [W-1:0] word_q;
  logic         take;

  nrz_level_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ack_async),
    .q_sync  (ack_seen)
  );

  assign s_ready = !levels_differ(req_q, ack_seen);
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      word_q <= '0;
    end else if (take) begin
      word_q <= s_data;
      req_q  <= ~req_q;
    end
  end

  assign req_out  = req_q;
  assign word_out = word_q;
endmodule

// File: rtl/nrz_rx_side.sv
module nrz_rx_side #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_async,
  input  logic [W-1:0] word_in,
  output logic         ack_out,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  import nrz_link_pkg::*;

  logic         req_seen;
  logic         ack_q;
  logic         full_q;
  logic [W-1:0] out_q;
  logic         pending;
  logic         room;
  logic         load;

  nrz_level_sync #(.STAGES(STAGES)) u_req_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (req_async),
    .q_sync  (req_seen)
  );

  assign pending = levels_differ(req_seen, ack_q);
  assign room    = !full_q || m_ready;
  assign load    = pending && room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      full_q <= 1'b0;
      out_q  <= '0;
    end else begin
      if (load) begin
        out_q  <= word_in;
        full_q <= 1'b1;
        ack_q  <= req_seen;
      end else if (m_ready) begin
        full_q <= 1'b0;
      end
    end
  end

  assign ack_out = ack_q;
  assign m_valid = full_q;
  assign m_data  = out_q;
endmodule

// File: rtl/nrz_word_link.sv
module nrz_word_link #(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data,
  output logic         link_req,
  output logic         link_ack
);
  logic [W-1:0] xfer_word;

  nrz_tx_side #(.W(W), .STAGES(SYNC_STAGES)) u_tx (
    .clk       (src_clk),
    .rst_n     (src_rst_n),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .ack_async (link_ack),
    .req_out   (link_req),
    .word_out  (xfer_word)
  );

  nrz_rx_side #(.W(W), .STAGES(SYNC_STAGES)) u_rx (
    .clk       (dst_clk),
    .rst_n     (dst_rst_n),
    .req_async (link_req),
    .word_in   (xfer_word),
    .ack_out   (link_ack),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data)
  );
endmodule

// File: rtl/nrz_word_link_chk.sv
module nrz_word_link_chk #(
  parameter int unsigned W = 16
) (
  input logic         src_clk,
  input logic         src_rst_n,
  input logic         dst_clk,
  input logic         dst_rst_n,
  input logic         s_valid,
  input logic         s_ready,
  input logic         m_valid,
  input logic         m_ready,
  input logic [W-1:0] m_data,
  input logic         link_req,
  input logic         link_ack,
  input logic [W-1:0] xfer_word
);
  // R2
  p_busy_after_take_r2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (s_valid && s_ready) |=> !s_ready);
  // R3
  p_req_flips_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (s_valid && s_ready) |=> (link_req != $past(link_req)));
  p_req_holds_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !(s_valid && s_ready) |=> $stable(link_req));
  // R4
  p_word_stable_r4: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !s_ready |=> $stable(xfer_word));
  // R5
  p_hold_out_r5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(link_ack)));
  // R8
  p_ack_on_load_r8: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !$stable(link_ack) |-> m_valid);
endmodule

bind nrz_word_link nrz_word_link_chk #(.W(W)) u_chk (
  .src_clk   (src_clk),
  .src_rst_n (src_rst_n),
  .dst_clk   (dst_clk),
  .dst_rst_n (dst_rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data),
  .link_req  (link_req),
  .link_ack  (link_ack),
  .xfer_word (xfer_word)
);

// File: tb/nrz_word_link_bench.sv
`timescale 1ns/1ps
module nrz_word_link_bench;
  localparam int W = 16;

  typedef struct packed {
    logic [7:0]  src_half;
    logic [7:0]  dst_half;
    logic [7:0]  n_words;
    logic [15:0] base;
    logic [7:0]  stall_mask;
  } row_t;

  // src half period, dst half period (ns), word count, first value, m_ready pattern
  localparam row_t ROWS [5] = '{
    '{8'd2, 8'd2, 8'd16, 16'h1000, 8'hFF},
    '{8'd2, 8'd7, 8'd12, 16'h2000, 8'hFF},
    '{8'd9, 8'd2, 8'd12, 16'h3000, 8'hFF},
    '{8'd2, 8'd3, 8'd16, 16'h4000, 8'b1011_0110},
    '{8'd5, 8'd3, 8'd10, 16'h5000, 8'b0101_0101}
  };

  logic src_clk = 0, dst_clk = 0;
  logic src_rst_n = 0, dst_rst_n = 0;
  logic s_valid = 0, m_ready = 0;
  logic [W-1:0] s_data = '0;
  logic s_ready, m_valid, link_req, link_ack;
  logic [W-1:0] m_data;

  int src_half = 2, dst_half = 2;
  int tests = 0, fails = 0;
  int req_flips = 0, ack_flips = 0;
  int got;
  logic [W-1:0] recv [64];
  logic prev_req = 0, prev_ack = 0;

  always begin #(src_half * 1ns); src_clk = ~src_clk; end
  always begin #(dst_half * 1ns); dst_clk = ~dst_clk; end

  always @(posedge src_clk) begin
    if (link_req !== prev_req) req_flips++;
    prev_req = link_req;
  end
  always @(posedge dst_clk) begin
    if (link_ack !== prev_ack) ack_flips++;
    prev_ack = link_ack;
  end

  nrz_word_link #(.W(W), .SYNC_STAGES(2)) u_nrz_word_link (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .dst_clk(dst_clk),
    .dst_rst_n(dst_rst_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .link_req(link_req), .link_ack(link_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    s_valid = 0; m_ready = 0;
    src_rst_n = 0; dst_rst_n = 0;
    repeat (3) @(posedge src_clk);
    repeat (3) @(posedge dst_clk);
    @(negedge src_clk); src_rst_n = 1;
    @(negedge dst_clk); dst_rst_n = 1;
    prev_req = 0; prev_ack = 0; req_flips = 0; ack_flips = 0; got = 0;
  endtask

  // Called at a source negedge; returns at a source negedge after acceptance.
  task automatic push(input logic [W-1:0] v);
    logic took;
    s_valid = 1; s_data = v;
    forever begin
      took = s_ready;
      @(posedge src_clk);
      @(negedge src_clk);
      if (took) break;
    end
    s_valid = 0;
  endtask

  task automatic drain(input int n, input logic [7:0] mask);
    logic take;
    logic [W-1:0] d;
    for (int k = 0; k < 6000 && got < n; k++) begin
      @(negedge dst_clk);
      m_ready = mask[k % 8];
      take = m_valid && m_ready;
      d = m_data;
      @(posedge dst_clk);
      if (take) begin recv[got] = d; got++; end
    end
    @(negedge dst_clk);
    m_ready = 0;
  endtask

  initial begin
    #400us;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    @(negedge src_clk);
    check("R1 s_ready", s_ready, 1);
    check("R1 m_valid", m_valid, 0);
    check("R1 link_req", link_req, 0);
    check("R1 link_ack", link_ack, 0);

    // Table walk: R3 R4 R7 R8
    foreach (ROWS[r]) begin
      src_half = ROWS[r].src_half; dst_half = ROWS[r].dst_half;
      do_reset();
      @(negedge src_clk);
      fork
        for (int i = 0; i < ROWS[r].n_words; i++) push(ROWS[r].base + 16'(i * 3));
        drain(ROWS[r].n_words, ROWS[r].stall_mask);
      join
      repeat (10) @(posedge src_clk);
      @(negedge src_clk);
      check("R7 delivered count", got, ROWS[r].n_words);
      for (int i = 0; i < got; i++)
        check("R4 word order/value", recv[i], ROWS[r].base + 16'(i * 3));
      check("R3 req toggles", req_flips, ROWS[r].n_words);
      check("R8 ack toggles", ack_flips, ROWS[r].n_words);
      check("R8 idle req==ack", link_req == link_ack, 1);
      check("R2 ready when idle", s_ready, 1);
    end

    // R2 and R6: busy after accept, offers while busy ignored
    src_half = 2; dst_half = 5;
    do_reset();
    @(negedge src_clk);
    push(16'hA5A5);
    check("R2 busy next cycle", s_ready, 0);
    s_valid = 1; s_data = 16'hDEAD;
    for (int k = 0; k < 200 && !s_ready; k++) @(negedge src_clk);
    s_valid = 0;
    drain(2, 8'hFF);
    check("R6 one word delivered", got, 1);
    check("R6 word intact", recv[0], 16'hA5A5);

    // R5: stalled sink with a second word pending
    do_reset();
    @(negedge src_clk);
    push(16'h1111);
    push(16'h2222);
    repeat (40) @(negedge dst_clk);
    check("R5 valid held", m_valid, 1);
    check("R5 data held", m_data, 16'h1111);
    check("R5 ack not flipped for second word", ack_flips, 1);
    @(negedge src_clk);
    check("R5 source still busy", s_ready, 0);
    drain(2, 8'hFF);
    check("R5 count after release", got, 2);
    check("R5 first", recv[0], 16'h1111);
    check("R5 second", recv[1], 16'h2222);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule